// File: doc/BRIEF.md
# Multi-Channel Glitch Capture Sampler

This block records eight already-synchronized logic channels at a programmable sample rate taken from a fast system clock. Each sample strobe writes the current channel word into a sample memory. Between two adjacent strobes, every channel's edges are counted. A channel that changes state two or more times in one interval is marked in a per-channel flag word, which goes to a separate glitch memory. Short pulses between slow samples are therefore not lost, and the recorded sample values are exactly what plain sampling would have stored.

Software or a controller sets the sample period and raises `run`. The block then writes one sample per strobe at consecutive addresses, starting at zero. It stops and raises `full` after it writes the last location. Both memories share the write address. The memories accept every write in the cycle it is offered, so the write ports are plain enables and carry no back-pressure. Dropping `run` halts writing at once and returns the block to its idle state.

Top module: `gcs_sampler`

## Requirements
- R1: While `run` is high, a sample strobe occurs every P clock cycles, where P is the effective period. The first strobe falls in the P-th cycle in which `run` is high.
- R2: In each strobe cycle (unless `full`), `smp_we` is high for exactly that cycle and `smp_data` equals `chan_in` in that same cycle. Glitch detection never changes `smp_data`.
- R3: Bit k of `glt_flags` is 1 when channel k changed value two or more times in the interval. The interval runs from the cycle after the previous strobe up to and including the strobe cycle. For the first interval after `run` rises, edges are counted relative to the channel value in the cycle before `run` rose.
- R4: A single edge in an interval does not set the flag. Three or more edges set it just as two do, because the count saturates. Counting restarts from zero in each interval.
- R5: An edge that occurs in the strobe cycle itself counts toward the interval that this strobe closes. It can therefore complete a glitch together with an earlier edge.
- R6: `glt_we` is high in a write cycle exactly when at least one flag bit is set. `glt_flags` is valid whenever `smp_we` is high. The glitch write uses the same `wr_addr` as the sample write.
- R7: After reset or a restart, the first write goes to address 0. Each later write goes to the next address.
- R8: After the write at address DEPTH-1 (default 4059), `full` rises on the next cycle and stays high while `run` is high. No further write occurs.
- R9: When `run` is low, no write occurs in that same cycle. On the next cycle the divider, the edge counters, the address and `full` are all cleared. A partial interval cut off by a stop is discarded.
- R10: `div_period` gives the period in clock cycles. The values 0 and 1 are treated as 2, so the minimum period is two cycles and two strobes are never adjacent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Acquisition enable; low stops and clears |
| div_period | input | 32 | Sample period in clock cycles (minimum 2) |
| chan_in | input | 8 | Synchronized channel inputs |
| smp_we | output | 1 | Sample memory write enable |
| smp_data | output | 8 | Sample word to write |
| glt_we | output | 1 | Glitch memory write enable |
| glt_flags | output | 8 | Per-channel glitch flags to write |
| wr_addr | output | 12 | Shared write address |
| full | output | 1 | Last location written; acquisition halted |

## Verification
Two functions meet in the strobe cycle: capturing the sample word, and closing and clearing the per-channel edge count. The bench provokes this collision in two ways. It toggles a channel exactly on the strobe cycle after one earlier toggle, and it toggles a channel once only on the strobe cycle. The scoreboard then expects the new level in the sample word and a flag only in the first case. It also expects the next interval to start counting from zero, not to inherit the edge.

// File: rtl/gcs_pkg.sv
`timescale 1ns/1ps
package gcs_pkg;
  localparam int unsigned GCS_CHANNELS  = 8;
  localparam int unsigned GCS_DEPTH     = 4060;
  localparam int unsigned GCS_DIV_W     = 32;
  localparam int unsigned GCS_MIN_DIV   = 2;
  localparam int unsigned GCS_CNT_W     = 2;
endpackage

// File: rtl/gcs_strobe_gen.sv
`timescale 1ns/1ps
module gcs_strobe_gen #(
  parameter int unsigned DIV_W   = gcs_pkg::GCS_DIV_W,
  parameter int unsigned MIN_DIV = gcs_pkg::GCS_MIN_DIV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_period,
  output logic             strobe_o
);
  localparam logic [DIV_W-1:0] MIN_P = DIV_W'(MIN_DIV);

  logic [DIV_W-1:0] period;
  logic [DIV_W-1:0] tick_q;

  always_comb begin
    period   = (div_period < MIN_P) ? MIN_P : div_period;
    strobe_o = run && (tick_q >= period - DIV_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tick_q <= '0;
    else if (!run)     tick_q <= '0;
    else if (strobe_o) tick_q <= '0;
    else               tick_q <= tick_q + DIV_W'(1);
  end

  // R10: the period never falls below two cycles
  a_r10_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/gcs_edge_tracker.sv
`timescale 1ns/1ps
module gcs_edge_tracker #(
  parameter int unsigned CNT_W = gcs_pkg::GCS_CNT_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic strobe,
  input  logic chan,
  output logic flag_o
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_sat;
  logic [CNT_W:0]   total;
  logic             edge_now;

  always_comb begin
    edge_now = chan ^ prev_q;
    cnt_sat  = (edge_now && cnt_q != SAT) ? cnt_q + CNT_W'(1) : cnt_q;
    total    = {1'b0, cnt_q} + {{CNT_W{1'b0}}, edge_now};
    flag_o   = strobe && (total >= (CNT_W+1)'(2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= chan;
      if (!run || strobe) cnt_q <= '0;
      else                cnt_q <= cnt_sat;
    end
  end

  // R4: every interval starts counting from zero
  a_r4_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> cnt_q == '0);
endmodule

// File: rtl/gcs_addr_ctrl.sv
`timescale 1ns/1ps
module gcs_addr_ctrl #(
  parameter int unsigned DEPTH = gcs_pkg::GCS_DEPTH,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          strobe,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic          full_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;
  logic          full_q;

  assign we_o   = strobe && run && !full_q;
  assign addr_o = addr_q;
  assign full_o = full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      full_q <= 1'b0;
    end else if (!run) begin
      addr_q <= '0;
      full_q <= 1'b0;
    end else if (we_o) begin
      if (addr_q == LAST) full_q <= 1'b1;
      else                addr_q <= addr_q + AW'(1);
    end
  end

  // R7: consecutive writes use consecutive addresses
  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    (we_o && addr_q != LAST) |=> addr_q == $past(addr_q) + AW'(1));
  // R8: full holds while running
  a_r8_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && run) |=> full_q);
  // R9: a stop clears the address and full
  a_r9_stop_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (addr_q == '0 && !full_q));
endmodule

// File: rtl/gcs_sampler.sv
`timescale 1ns/1ps
module gcs_sampler #(
  parameter int unsigned CHANNELS = gcs_pkg::GCS_CHANNELS,
  parameter int unsigned DEPTH    = gcs_pkg::GCS_DEPTH,
  parameter int unsigned DIV_W    = gcs_pkg::GCS_DIV_W,
  localparam int unsigned AW      = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [DIV_W-1:0]    div_period,
  input  logic [CHANNELS-1:0] chan_in,
  output logic                smp_we,
  output logic [CHANNELS-1:0] smp_data,
  output logic                glt_we,
  output logic [CHANNELS-1:0] glt_flags,
  output logic [AW-1:0]       wr_addr,
  output logic                full
);
  logic                strobe;
  logic                we;
  logic [CHANNELS-1:0] flags;

  gcs_strobe_gen #(.DIV_W(DIV_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .run(run),
    .div_period(div_period), .strobe_o(strobe)
  );

  for (genvar k = 0; k < CHANNELS; k++) begin : g_chan
    gcs_edge_tracker u_track (
      .clk(clk), .rst_n(rst_n), .run(run), .strobe(strobe),
      .chan(chan_in[k]), .flag_o(flags[k])
    );
  end

  gcs_addr_ctrl #(.DEPTH(DEPTH)) u_addr (
    .clk(clk), .rst_n(rst_n), .run(run), .strobe(strobe),
    .we_o(we), .addr_o(wr_addr), .full_o(full)
  );

  assign smp_we    = we;
  assign smp_data  = chan_in;
  assign glt_flags = flags;
  assign glt_we    = we && (|flags);
endmodule

// File: tb/test_gcs_sampler.sv
`timescale 1ns/1ps
module test_gcs_sampler;
  localparam int DEPTH = 4060;

  typedef struct packed {
    logic [11:0] a;
    logic [7:0]  d;
    logic [7:0]  g;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [31:0] div_period = 32'd5;
  logic [7:0]  chan_in = 8'h00;
  logic        smp_we, glt_we, full;
  logic [7:0]  smp_data, glt_flags;
  logic [11:0] wr_addr;

  int checks = 0;
  int fails  = 0;
  int exp_n  = 0;
  item_t q[$];

  always #2 clk = ~clk;

  gcs_sampler i_gcs_sampler (
    .clk(clk), .rst_n(rst_n), .run(run), .div_period(div_period),
    .chan_in(chan_in), .smp_we(smp_we), .smp_data(smp_data),
    .glt_we(glt_we), .glt_flags(glt_flags), .wr_addr(wr_addr), .full(full)
  );

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: R2 R3 R6 R7 scoreboard
  always @(negedge clk) begin
    if (rst_n && smp_we) begin
      if (q.size() == 0) begin
        check("R8/R9 unexpected write", 1'b0, wr_addr, 0);
      end else begin
        item_t e;
        e = q.pop_front();
        check("R7 address", wr_addr == e.a, wr_addr, e.a);
        check("R2 sample word", smp_data == e.d, smp_data, e.d);
        check("R6 glitch enable", glt_we == (|e.g), glt_we, |e.g);
        check("R3 glitch flags", glt_flags == e.g, glt_flags, e.g);
      end
    end
  end

  // drive one interval of p cycles; masks for cycles 1..5 packed low first
  task automatic interval(input int p, input logic [39:0] tg, input bit close);
    int ec [8];
    logic [7:0] gl;
    for (int b = 0; b < 8; b++) ec[b] = 0;
    for (int j = 1; j <= p; j++) begin
      logic [7:0] m;
      m = (j <= 5) ? tg[8*(j-1) +: 8] : 8'h00;
      for (int b = 0; b < 8; b++) if (m[b]) ec[b]++;
      chan_in = chan_in ^ m;
      if (j == p && close) begin
        gl = '0;
        for (int b = 0; b < 8; b++) gl[b] = (ec[b] >= 2);
        if (exp_n < DEPTH) q.push_back('{a: 12'(exp_n), d: chan_in, g: gl});
        exp_n++;
      end
      @(posedge clk); #1;
    end
  endtask

  task automatic stop();
    run = 1'b0;
    exp_n = 0;
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 4);
    check("watchdog", 1'b0, 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset write idle", smp_we == 1'b0, smp_we, 0);
    check("R8 reset full low", full == 1'b0, full, 0);
    check("R7 reset address", wr_addr == 12'd0, wr_addr, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 period 5; R3 R4 R5 patterns
    div_period = 32'd5;
    run = 1'b1;
    interval(5, 40'h0, 1'b1);                          // quiet
    interval(5, {8'h00, 8'h00, 8'h01, 8'h00, 8'h00}, 1'b1); // R4 single edge
    interval(5, {8'h00, 8'h00, 8'h00, 8'h02, 8'h02}, 1'b1); // R3 pulse
    interval(5, {8'h00, 8'h04, 8'h04, 8'h00, 8'h04}, 1'b1); // R4 saturate
    interval(5, {8'h08, 8'h00, 8'h00, 8'h00, 8'h08}, 1'b1); // R5 edge on strobe
    interval(5, {8'h10, 8'h00, 8'h00, 8'h00, 8'h00}, 1'b1); // R5 lone strobe edge
    interval(5, 40'h0, 1'b1);                          // R4 no carry over
    interval(5, {8'hF0, 8'h0F, 8'hA5, 8'h5A, 8'hFF}, 1'b1); // mixed
    // R9 partial interval discarded
    interval(3, {8'h00, 8'h00, 8'hC0, 8'h40, 8'h40}, 1'b0);
    stop();
    check("R9 full cleared", full == 1'b0, full, 0);
    check("R9 address cleared", wr_addr == 12'd0, wr_addr, 0);
    check("R9 queue drained", q.size() == 0, q.size(), 0);

    // R10 period 0 acts as 2
    div_period = 32'd0;
    run = 1'b1;
    interval(2, {8'h80, 8'h80}, 1'b1);
    interval(2, {8'h01, 8'h00}, 1'b1);
    stop();
    div_period = 32'd1;
    run = 1'b1;
    // fill memory (R8)
    for (int i = 0; i < DEPTH + 4; i++) begin
      logic [7:0] a0, a1;
      a0 = 8'(i);
      a1 = 8'(i * 3) & 8'h55;
      interval(2, {24'h0, a1, a0}, 1'b1);
    end
    check("R8 full asserted", full == 1'b1, full, 1);
    check("R8 address held at last", wr_addr == 12'(DEPTH - 1), wr_addr, DEPTH - 1);
    check("R8 queue drained", q.size() == 0, q.size(), 0);
    stop();
    check("R9 full cleared after stop", full == 1'b0, full, 0);

    // R7 restart at address 0 with period 3
    div_period = 32'd3;
    run = 1'b1;
    interval(3, {8'h00, 8'h22, 8'h22}, 1'b1);
    interval(3, {8'h11, 8'h00, 8'h00}, 1'b1);
    stop();
    @(negedge clk);
    check("end queue drained", q.size() == 0, q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule